// File: doc/BRIEF.md
# Fractional baud rate generator

This block turns a fixed system clock into a one-cycle bit strobe for a serial transmitter or receiver. A two-bit clock-select input picks a reference rate of the system clock divided by 1, 2, 4 or 8. A 16-bit fixed-point divisor, 13 integer bits over 3 fractional bits, gives the bit period in reference clocks, counted in eighths. A phase accumulator gains 8 eighths on every reference step and emits a strobe each time it reaches the divisor. Because the remainder is kept rather than thrown away, the fractional part is spread over successive bits and the long-run period equals the divisor exactly.

A restart pulse realigns the reference prescaler and preloads the accumulator with half the divisor, so a receiver that has just seen a start edge gets its first strobe in the middle of the bit. New divisor and clock-select values are taken up only at a strobe, at a restart, or when the block leaves its error state, so a period never ends early. A divisor below 8.0 (raw value below 64) raises an error flag and stops the strobes. When a legal value is applied, the flag drops and counting begins again from a zero phase.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted and in the cycle after it, `bit_tick` and `config_error` are both 0.
- R2: A reference step occurs every 2^`clk_sel` system cycles: `clk_sel` 0, 1, 2, 3 select division by 1, 2, 4, 8. The prescaler restarts its count at every adoption point (strobe, restart, start-up, error recovery).
- R3: After an adoption point at edge t0 with starting phase A0 (in eighths), strobe k is registered at edge t0 + ceil((k*D - A0)/8) * 2^`clk_sel`, where D is the raw divisor. Any 8 consecutive bit periods therefore span exactly D reference steps. Start-up uses A0 = 0.
- R4: `bit_tick` is high for exactly one system cycle per strobe.
- R5: A raw `divisor` below 64 sets `config_error` from the next cycle on. While the flag is set, no strobe is produced.
- R6: When a legal divisor is applied during the error state, `config_error` clears in the next cycle. Counting then restarts from A0 = 0 at that edge, with the current `clk_sel`.
- R7: A `restart` pulse with a legal divisor loads the phase with floor(D/2) and realigns the prescaler at that edge. This takes priority over a strobe in the same cycle.
- R8: A `divisor` change in the middle of a period does not move the pending strobe. The new value governs the periods after it, starting from the remainder left by that strobe.
- R9: A `clk_sel` change in the middle of a period does not alter the pending strobe. The new rate applies after the next strobe or restart.
- R10: The smallest legal divisor, 64, with `clk_sel` = 0 produces a strobe every 8 system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (the base rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Reference divide select: 2^clk_sel |
| divisor | input | 16 | Bit period in eighths of a reference clock |
| restart | input | 1 | One-cycle phase realign to mid-bit |
| bit_tick | output | 1 | One-cycle bit strobe |
| config_error | output | 1 | Divisor below 8.0 is present |

## Verification
The assertions assume the following about the inputs: `restart` is a single-cycle pulse, and inputs change away from the active clock edge. The one-cycle-strobe and prescaler-gap properties also assume that only legal divisors, 64 and above, are ever adopted. The block guarantees that last part itself, since it refuses to adopt an illegal value. The bench drives every input at the falling edge and holds the divisor at 64 or above except in the error scenario. There it holds 50 for a window with no strobes expected, then returns to a legal value before the next restart.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int unsigned DIV_W_DEF  = 16;
  localparam int unsigned FRAC_W_DEF = 3;
  localparam int unsigned SEL_W_DEF  = 2;

  // what the phase accumulator does on the next edge
  typedef enum logic [2:0] {
    ACT_IDLE = 3'd0,  // hold phase
    ACT_STEP = 3'd1,  // add one reference clock
    ACT_WRAP = 3'd2,  // add, subtract divisor, strobe
    ACT_HALF = 3'd3,  // preload half divisor (restart)
    ACT_ZERO = 3'd4   // clear phase (start-up, error recovery)
  } acc_act_e;

  // one whole reference clock expressed in divisor units
  function automatic int unsigned unit_step(input int unsigned frac_w);
    return 32'd1 << frac_w;
  endfunction

  // smallest legal divisor: 8.0 reference clocks
  function automatic int unsigned min_divisor(input int unsigned frac_w);
    return 32'd8 << frac_w;
  endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned SEL_W = baud_pkg::SEL_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [SEL_W-1:0] sel,
  output logic             ref_en
);
  localparam int unsigned NSEL  = 2 ** SEL_W;
  localparam int unsigned CNT_W = NSEL - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask_tab [NSEL];
  logic [CNT_W-1:0] mask;

  for (genvar g = 0; g < NSEL; g++) begin : g_mask
    assign mask_tab[g] = CNT_W'((64'd1 << g) - 64'd1);
  end

  assign mask   = mask_tab[sel];
  assign ref_en = ((cnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // R2: with division above 1, two reference steps are never adjacent
  a_r2_step_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_en && (sel != '0) && !clear) |=> !ref_en);

endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W  = DIV_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acc_act_e         act,
  input  logic [DIV_W-1:0] div_act,
  input  logic [DIV_W-1:0] div_new,
  output logic             hit
);
  localparam int unsigned ACC_W = DIV_W + 1;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(unit_step(FRAC_W));

  function automatic logic [ACC_W-1:0] widen(input logic [DIV_W-1:0] d);
    return {1'b0, d};
  endfunction

  function automatic logic [ACC_W-1:0] half_phase(input logic [DIV_W-1:0] d);
    return widen(d >> 1);
  endfunction

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  assign sum = acc_q + STEP;
  assign hit = (sum >= widen(div_act));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else begin
      unique case (act)
        ACT_STEP: acc_q <= sum;
        ACT_WRAP: acc_q <= sum - widen(div_act);
        ACT_HALF: acc_q <= half_phase(div_new);
        ACT_ZERO: acc_q <= '0;
        default:  acc_q <= acc_q;
      endcase
    end
  end

  // R3: phase always stays below the period in force
  a_r3_phase_below_div: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < widen(div_act));

  // R7: restart leaves exactly half the new divisor in the phase
  a_r7_half_load: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_HALF) |=> (acc_q == {1'b0, $past(div_new) >> 1}));

endmodule

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W  = DIV_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF,
  parameter int unsigned SEL_W  = SEL_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             restart,
  input  logic             ref_en,
  input  logic             hit,
  output acc_act_e         act,
  output logic             realign,
  output logic [DIV_W-1:0] div_act,
  output logic [SEL_W-1:0] sel_act,
  output logic             err,
  output logic             tick
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(min_divisor(FRAC_W));

  logic init_q;
  logic legal;

  function automatic logic div_ok(input logic [DIV_W-1:0] d);
    return d >= MIN_DIV;
  endfunction

  assign legal = div_ok(divisor);

  always_comb begin
    if (!legal)              act = ACT_IDLE;
    else if (restart)        act = ACT_HALF;
    else if (init_q || err)  act = ACT_ZERO;
    else if (ref_en)         act = hit ? ACT_WRAP : ACT_STEP;
    else                     act = ACT_IDLE;
  end

  assign realign = (act == ACT_WRAP) || (act == ACT_HALF) || (act == ACT_ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q  <= 1'b1;
      err     <= 1'b0;
      tick    <= 1'b0;
      div_act <= MIN_DIV;
      sel_act <= '0;
    end else begin
      init_q <= 1'b0;
      err    <= !legal;
      tick   <= (act == ACT_WRAP);
      if (realign) begin
        div_act <= divisor;
        sel_act <= clk_sel;
      end
    end
  end

  // R5: no strobe is ever issued while the error flag is up
  a_r5_quiet_in_error: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !tick);

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W  = DIV_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF,
  parameter int unsigned SEL_W  = SEL_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [DIV_W-1:0] divisor,
  input  logic             restart,
  output logic             bit_tick,
  output logic             config_error
);
  acc_act_e         act;
  logic             realign;
  logic             ref_en;
  logic             hit;
  logic [DIV_W-1:0] div_act;
  logic [SEL_W-1:0] sel_act;

  baud_ctrl #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .SEL_W(SEL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .divisor (divisor),
    .clk_sel (clk_sel),
    .restart (restart),
    .ref_en  (ref_en),
    .hit     (hit),
    .act     (act),
    .realign (realign),
    .div_act (div_act),
    .sel_act (sel_act),
    .err     (config_error),
    .tick    (bit_tick)
  );

  baud_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (realign),
    .sel    (sel_act),
    .ref_en (ref_en)
  );

  baud_phase_acc #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .div_act (div_act),
    .div_new (divisor),
    .hit     (hit)
  );

  // R4 and R10: a strobe never lasts two cycles
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

endmodule

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  clk_sel = 2'd0;
  logic [15:0] divisor = 16'd100;
  logic        restart = 1'b0;
  logic        bit_tick;
  logic        config_error;

  always #2 clk = ~clk;  // 250 MHz

  frac_baud_gen i_frac_baud_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_sel      (clk_sel),
    .divisor      (divisor),
    .restart      (restart),
    .bit_tick     (bit_tick),
    .config_error (config_error)
  );

  int    vectors = 0;
  int    miscompares = 0;
  int    edge_no = 0;
  int    exp_q[$];
  string cur_req = "R3";
  int    ticks_seen = 0;
  int    last_tick = -1;
  int    last_gap = 0;
  logic  prev_tick = 1'b0;
  int    now_e;
  bit    done = 1'b0;

  always @(posedge clk) if (rst_n) edge_no <= edge_no + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe k after an adoption at t0: ceil((k*d - a0)/8) reference steps
  function automatic int steps_to(input int k, input int d, input int a0);
    return (k * d - a0 + 7) / 8;
  endfunction

  task automatic plan_ticks(input int t0, input int a0, input int d, input int s,
                            input int count, output int last, output int rem);
    last = t0;
    for (int k = 1; k <= count; k++) begin
      last = t0 + (steps_to(k, d, a0) << s);
      exp_q.push_back(last);
    end
    rem = a0 + 8 * steps_to(count, d, a0) - count * d;
  endtask

  task automatic wait_until(input int n);
    while (edge_no < n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      now_e = edge_no - 1;
      while (exp_q.size() > 0 && exp_q[0] < now_e) begin
        check(1'b0, cur_req, -1, exp_q[0]);
        void'(exp_q.pop_front());
      end
      if (bit_tick) begin
        check(!prev_tick, "R4", 1, 0);
        ticks_seen++;
        last_gap  = now_e - last_tick;
        last_tick = now_e;
        if (exp_q.size() > 0 && exp_q[0] == now_e) begin
          check(1'b1, cur_req, now_e, now_e);
          void'(exp_q.pop_front());
        end else begin
          check(1'b0, cur_req, now_e, (exp_q.size() > 0) ? exp_q[0] : -1);
        end
      end
      prev_tick = bit_tick;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int last, rem, last2, rem2, n0, t_err;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(bit_tick == 1'b0, "R1", bit_tick, 0);
    check(config_error == 1'b0, "R1", config_error, 0);
    // start-up: D=100 (12.5), divide 1, phase 0 at edge 0
    cur_req = "R3";
    plan_ticks(0, 0, 100, 0, 8, last, rem);
    rst_n = 1'b1;
    @(negedge clk);
    check(bit_tick == 1'b0 && config_error == 1'b0, "R1", bit_tick, 0);
    wait_until(last + 2);
    // R3: eight periods from a zero phase span exactly D reference steps
    check(last_tick == 100, "R3", last_tick, 100);

    // R7 / R10: minimum divisor, restart preloads 32
    cur_req = "R10";
    n0 = edge_no;
    plan_ticks(n0, 32, 64, 0, 4, last, rem);
    divisor = 16'd64; clk_sel = 2'd0; restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    wait_until(last + 2);
    check(last_gap == 8, "R10", last_gap, 8);

    // R2: divide by 2 with fractional divisor 77 (9.625)
    cur_req = "R2";
    n0 = edge_no;
    plan_ticks(n0, 38, 77, 1, 8, last, rem);
    divisor = 16'd77; clk_sel = 2'd1; restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    wait_until(last + 2);
    check(last_tick - exp_q.size() == last, "R2", last_tick, last);

    // R2: divide by 4
    n0 = edge_no;
    plan_ticks(n0, 65, 130, 2, 3, last, rem);
    divisor = 16'd130; clk_sel = 2'd2; restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    wait_until(last + 2);

    // R2: divide by 8
    n0 = edge_no;
    plan_ticks(n0, 32, 64, 3, 3, last, rem);
    divisor = 16'd64; clk_sel = 2'd3; restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    wait_until(last + 2);
    check(last_gap == 64, "R2", last_gap, 64);

    // R7: odd divisor, floor half phase
    cur_req = "R7";
    n0 = edge_no;
    plan_ticks(n0, 45, 91, 0, 2, last, rem);
    divisor = 16'd91; clk_sel = 2'd0; restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    wait_until(last + 2);
    check(last_tick == n0 + 6 + 12, "R7", last_tick, n0 + 18);

    // R8: divisor change mid-period
    cur_req = "R8";
    n0 = edge_no;
    plan_ticks(n0, 40, 80, 0, 1, last, rem);
    plan_ticks(last, rem, 120, 0, 2, last2, rem2);
    divisor = 16'd80; clk_sel = 2'd0; restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    wait_until(n0 + 2);
    divisor = 16'd120;
    wait_until(last2 + 2);
    check(last_gap == 15, "R8", last_gap, 15);

    // R9: clock-select change mid-period
    cur_req = "R9";
    n0 = edge_no;
    plan_ticks(n0, 48, 96, 0, 1, last, rem);
    plan_ticks(last, rem, 96, 2, 2, last2, rem2);
    divisor = 16'd96; clk_sel = 2'd0; restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    wait_until(n0 + 2);
    clk_sel = 2'd2;
    wait_until(last2 + 2);
    check(last_gap == 48, "R9", last_gap, 48);

    // R5: illegal divisor, no strobes while held
    cur_req = "R5";
    clk_sel = 2'd0;
    divisor = 16'd50;
    t_err = ticks_seen;
    @(negedge clk);
    check(config_error == 1'b1, "R5", config_error, 1);
    repeat (40) @(negedge clk);
    check(config_error == 1'b1, "R5", config_error, 1);
    check(ticks_seen == t_err, "R5", ticks_seen - t_err, 0);

    // R6: recovery restarts from phase zero
    cur_req = "R6";
    n0 = edge_no;
    plan_ticks(n0, 0, 72, 0, 2, last, rem);
    divisor = 16'd72;
    @(negedge clk);
    check(config_error == 1'b0, "R6", config_error, 0);
    wait_until(last + 2);
    check(last_tick == n0 + 18, "R6", last_tick, n0 + 18);

    check(exp_q.size() == 0, "R3", exp_q.size(), 0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule